// File: doc/BRIEF.md
# Parity Write Coalescing Buffer

This block sits on the write path of a memory controller. Each cache-line write produces a 72-bit parity word. The block merges these words so that several of them reach DRAM in one write. Eight neighbouring lines keep their parity words side by side in a single 72-byte burst, and that burst sits in the same DRAM row as the lines' data. The buffer therefore holds a few burst-sized slots, each named by a tag. A tag is the line address with its three low bits removed. Those three bits pick one of eight 72-bit lanes inside the slot.

An incoming parity word is merged into the slot whose tag matches. If no slot matches, a new slot is opened. A slot leaves the buffer in two cases: when a new tag needs room and every slot is taken, or when a flush is requested. Each departure is one burst write that carries a lane mask, so that lanes nobody updated are left untouched in memory. With good locality, one burst write then stands for up to eight parity updates instead of eight separate ones.

Top module: `pwc_coalesce_buf`

## Requirements
- R1: After reset the buffer is empty: `wr_valid` is 0 and `in_ready` is 1.
- R2: An accepted word with address `a` is placed in the slot with tag `a >> 3`, in lane `a[2:0]`. That lane occupies `wr_data[72*lane +: 72]` and is flagged by `wr_mask[lane]`. Every burst that is issued has at least one mask bit set.
- R3: Words whose tags match are merged into one slot and leave the buffer together in a single burst. A word that matches a slot is never stalled, except while a flush is running.
- R4: A later word written to a lane that is already valid replaces the earlier value in that lane.
- R5: In an issued burst, every lane whose mask bit is 0 carries all-zero data.
- R6: Suppose every slot is taken and a word with a new tag is offered. The oldest slot is then presented on the write port. `in_ready` stays 0 until `wr_ready` is 1, and in that same cycle the new word is accepted into the freed slot.
- R7: A one-cycle `flush_req` pulse drains every slot, oldest first, one burst each. `in_ready` is 0 until the buffer is empty.
- R8: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_tag`, `wr_mask` and `wr_data` hold their values.
- R9: While a free slot remains and no flush is running, no burst is issued.
- R10: A flush on an empty buffer issues no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A parity word is offered |
| in_ready | output | 1 | The offered word is taken on this cycle's edge |
| in_addr | input | ADDR_W | Line address of the parity word |
| in_parity | input | 72 | Parity word for the line |
| flush_req | input | 1 | One-cycle pulse that asks for all slots to be drained |
| wr_valid | output | 1 | A burst write is presented |
| wr_ready | input | 1 | The memory side takes the burst on this edge |
| wr_tag | output | ADDR_W-3 | Burst tag (line address without its lane bits) |
| wr_mask | output | 8 | Lanes of the burst to be written |
| wr_data | output | 576 | Burst data, lane k at bits 72k and up |

## Verification
Two events can land in the same cycle: an eviction drain and the allocation of a new slot. This happens when the buffer is full, a word with a new tag is waiting, and `wr_ready` rises. The freed slot is then refilled on the very edge that releases the old one.

The bench provokes this case by filling all slots and then offering a fifth tag while holding `wr_ready` low. It checks the stall and the held burst, then raises `wr_ready`. The case is judged correct if three things hold:
- the oldest slot's burst comes out intact;
- a later flush returns the new tag with only its own lane set;
- every lane outside the mask is zero.

A second overlap, a flush pulse arriving while a slot is stalled on `wr_ready`, is judged by `in_ready` staying 0 and by the drain order.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  // burst geometry: eight 72-bit parity lanes fill one 72-byte burst
  localparam int LANE_BITS = 72;
  localparam int LANES     = 8;
  localparam int LSEL_W    = $clog2(LANES);
  localparam int BURST_W   = LANE_BITS * LANES;

  typedef logic [LANE_BITS-1:0] lane_word_t;
  typedef logic [BURST_W-1:0]   burst_t;
  typedef logic [LANES-1:0]     lane_mask_t;
  typedef logic [LSEL_W-1:0]    lane_sel_t;

  function automatic lane_mask_t lane_bit(lane_sel_t sel);
    lane_mask_t m;
    m = '0;
    m[sel] = 1'b1;
    return m;
  endfunction

  // fresh burst holding one word, every other lane cleared
  function automatic burst_t place_lane(lane_word_t w, lane_sel_t sel);
    burst_t b;
    b = '0;
    b[sel*LANE_BITS +: LANE_BITS] = w;
    return b;
  endfunction

  // replace one lane of an existing burst
  function automatic burst_t merge_lane(burst_t b, lane_word_t w, lane_sel_t sel);
    burst_t r;
    r = b;
    r[sel*LANE_BITS +: LANE_BITS] = w;
    return r;
  endfunction
endpackage

// File: rtl/pwc_tag_match.sv
module pwc_tag_match #(
  parameter int SLOTS = 4,
  parameter int TAG_W = 13,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0]            occ,
  input  logic [SLOTS-1:0][TAG_W-1:0] slot_tag,
  input  logic [TAG_W-1:0]            probe,
  output logic                        hit,
  output logic [IDX_W-1:0]            hit_idx
);
  logic [SLOTS-1:0] hit_vec;

  for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
    assign hit_vec[i] = occ[i] && (slot_tag[i] == probe);
  end

  assign hit = |hit_vec;

  // tags are unique among occupied slots, so the encoder sees at most one bit
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pwc_slot_store.sv
module pwc_slot_store
  import pwc_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int TAG_W = 13,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        alloc_en,
  input  logic [IDX_W-1:0]            alloc_idx,
  input  logic                        merge_en,
  input  logic [IDX_W-1:0]            merge_idx,
  input  logic [TAG_W-1:0]            upd_tag,
  input  lane_sel_t                   upd_lane,
  input  lane_word_t                  upd_word,
  output logic [SLOTS-1:0][TAG_W-1:0] slot_tag,
  output lane_mask_t [SLOTS-1:0]      slot_mask,
  output burst_t [SLOTS-1:0]          slot_data
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic sel_alloc, sel_merge;
    assign sel_alloc = alloc_en && (alloc_idx == IDX_W'(i));
    assign sel_merge = merge_en && (merge_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_tag[i]  <= '0;
        slot_mask[i] <= '0;
        slot_data[i] <= '0;
      end else if (sel_alloc) begin
        slot_tag[i]  <= upd_tag;
        slot_mask[i] <= lane_bit(upd_lane);
        slot_data[i] <= place_lane(upd_word, upd_lane);
      end else if (sel_merge) begin
        slot_mask[i] <= slot_mask[i] | lane_bit(upd_lane);
        slot_data[i] <= merge_lane(slot_data[i], upd_word, upd_lane);
      end
    end
  end
endmodule

// File: rtl/pwc_queue_ctrl.sv
module pwc_queue_ctrl #(
  parameter int SLOTS = 4,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             pop,
  input  logic             flush_req,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [SLOTS-1:0] occ,
  output logic             full,
  output logic             empty,
  output logic             flush_pend
);
  logic [CNT_W-1:0] count, count_n;

  function automatic logic [IDX_W-1:0] step(logic [IDX_W-1:0] i);
    return (i == IDX_W'(SLOTS - 1)) ? '0 : i + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(SLOTS));
  assign empty   = (count == '0);
  assign count_n = count + CNT_W'(alloc) - CNT_W'(pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head       <= '0;
      tail       <= '0;
      count      <= '0;
      occ        <= '0;
      flush_pend <= 1'b0;
    end else begin
      if (pop)   head <= step(head);
      if (alloc) tail <= step(tail);
      count <= count_n;
      for (int i = 0; i < SLOTS; i++) begin
        // when full, a freed head slot is reused at once: the set wins
        if (alloc && tail == IDX_W'(i))     occ[i] <= 1'b1;
        else if (pop && head == IDX_W'(i))  occ[i] <= 1'b0;
      end
      flush_pend <= (flush_pend || flush_req) && (count_n != '0);
    end
  end
endmodule

// File: rtl/pwc_coalesce_buf.sv
module pwc_coalesce_buf
  import pwc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SLOTS  = 4,
  localparam int TAG_W = ADDR_W - LSEL_W,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic [LANE_BITS-1:0] in_parity,
  input  logic               flush_req,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [TAG_W-1:0]   wr_tag,
  output logic [LANES-1:0]   wr_mask,
  output logic [BURST_W-1:0] wr_data
);
  logic [TAG_W-1:0]            in_tag;
  lane_sel_t                   in_lane;
  logic [SLOTS-1:0][TAG_W-1:0] slot_tag;
  lane_mask_t [SLOTS-1:0]      slot_mask;
  burst_t [SLOTS-1:0]          slot_data;
  logic [SLOTS-1:0]            occ;
  logic [IDX_W-1:0]            head, tail, hit_idx;
  logic hit, full, empty, flush_busy;
  logic evict_need, drain_req, pop, accept, alloc, merge;

  assign in_tag  = in_addr[ADDR_W-1:LSEL_W];
  assign in_lane = in_addr[LSEL_W-1:0];

  pwc_tag_match #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_match (
    .occ(occ), .slot_tag(slot_tag), .probe(in_tag),
    .hit(hit), .hit_idx(hit_idx)
  );

  // drain the head slot when flushing, or when a new tag finds no room
  assign evict_need = in_valid && !hit && full && !flush_busy;
  assign drain_req  = (flush_busy && !empty) || evict_need;
  assign pop        = drain_req && wr_ready;

  assign in_ready = !flush_busy && (hit || !full || wr_ready);
  assign accept   = in_valid && in_ready;
  assign alloc    = accept && !hit;
  assign merge    = accept && hit;

  pwc_queue_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .pop(pop), .flush_req(flush_req),
    .head(head), .tail(tail), .occ(occ), .full(full), .empty(empty),
    .flush_pend(flush_busy)
  );

  pwc_slot_store #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc), .alloc_idx(tail),
    .merge_en(merge), .merge_idx(hit_idx),
    .upd_tag(in_tag), .upd_lane(in_lane), .upd_word(in_parity),
    .slot_tag(slot_tag), .slot_mask(slot_mask), .slot_data(slot_data)
  );

  assign wr_valid = drain_req;
  assign wr_tag   = slot_tag[head];
  assign wr_mask  = slot_mask[head];
  assign wr_data  = slot_data[head];
endmodule

// File: rtl/pwc_coalesce_buf_chk.sv
module pwc_coalesce_buf_chk
  import pwc_pkg::*;
#(
  parameter int TAG_W = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [TAG_W-1:0]   wr_tag,
  input logic [LANES-1:0]   wr_mask,
  input logic [BURST_W-1:0] wr_data,
  input logic               full,
  input logic               hit,
  input logic               flush_busy
);
  function automatic logic lanes_clear(logic [BURST_W-1:0] d, logic [LANES-1:0] m);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      if (!m[k] && d[k*LANE_BITS +: LANE_BITS] != '0) ok = 1'b0;
    end
    return ok;
  endfunction

  assert_mask_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_mask != '0));

  assert_merge_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hit && !flush_busy) |-> in_ready);

  assert_lanes_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> lanes_clear(wr_data, wr_mask));

  assert_evict_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !hit && !flush_busy && !wr_ready) |-> (wr_valid && !in_ready));

  assert_flush_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |-> !in_ready);

  assert_burst_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=>
      (wr_valid && $stable(wr_tag) && $stable(wr_mask) && $stable(wr_data)));

  assert_quiet_with_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && !flush_busy) |-> !wr_valid);
endmodule

bind pwc_coalesce_buf pwc_coalesce_buf_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_tag(wr_tag),
  .wr_mask(wr_mask), .wr_data(wr_data), .full(full), .hit(hit),
  .flush_busy(flush_busy)
);

// File: tb/pwc_coalesce_buf_tb.sv
`timescale 1ns/1ps
module pwc_coalesce_buf_tb;
  localparam int AW = 16;
  localparam int TW = 13;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [71:0] in_parity = '0;
  logic flush_req = 1'b0;
  logic wr_ready = 1'b1;
  logic in_ready, wr_valid;
  logic [TW-1:0] wr_tag;
  logic [7:0] wr_mask;
  logic [575:0] wr_data;

  always #10 clk = ~clk;  // 50 MHz

  pwc_coalesce_buf #(.ADDR_W(AW), .SLOTS(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_parity(in_parity), .flush_req(flush_req),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_tag(wr_tag),
    .wr_mask(wr_mask), .wr_data(wr_data)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  // addr[23:8], byte seed[7:0]; word = seed repeated nine times
  localparam logic [23:0] VEC [10] = '{
    24'h0010A1, 24'h0013B2, 24'h0020C3, 24'h0013D4, 24'h0037E5,
    24'h0041F6, 24'h002417, 24'h005028, 24'h001739, 24'h00454A
  };

  // reference model: slots in age order, index 0 oldest
  logic [TW-1:0] m_tag [NS];
  logic [7:0]    m_mask[NS];
  logic [575:0]  m_data[NS];
  int m_cnt = 0;
  logic [TW-1:0] e_tag [64]; logic [7:0] e_mask[64]; logic [575:0] e_data[64];
  int n_exp = 0;
  logic [TW-1:0] l_tag [64]; logic [7:0] l_mask[64]; logic [575:0] l_data[64];
  int n_log = 0;

  function automatic logic [575:0] put_lane(int lane, logic [71:0] w);
    logic [575:0] b = '0;
    b[lane*72 +: 72] = w;
    return b;
  endfunction

  task automatic chk(string req, logic [575:0] act, logic [575:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_exp(int k);
    e_tag[n_exp] = m_tag[k]; e_mask[n_exp] = m_mask[k]; e_data[n_exp] = m_data[k];
    n_exp++;
  endtask

  task automatic model_accept(logic [AW-1:0] a, logic [71:0] w);
    logic [TW-1:0] t = a[AW-1:3];
    int lane = int'(a[2:0]);
    int found = -1;
    for (int k = 0; k < m_cnt; k++) if (m_tag[k] == t) found = k;
    if (found >= 0) begin
      m_mask[found][lane] = 1'b1;
      m_data[found][lane*72 +: 72] = w;
    end else begin
      if (m_cnt == NS) begin
        push_exp(0);
        for (int k = 1; k < NS; k++) begin
          m_tag[k-1] = m_tag[k]; m_mask[k-1] = m_mask[k]; m_data[k-1] = m_data[k];
        end
        m_cnt--;
      end
      m_tag[m_cnt] = t; m_mask[m_cnt] = 8'h0; m_mask[m_cnt][lane] = 1'b1;
      m_data[m_cnt] = put_lane(lane, w);
      m_cnt++;
    end
  endtask

  task automatic model_flush();
    for (int k = 0; k < m_cnt; k++) push_exp(k);
    m_cnt = 0;
  endtask

  // transfer monitor, sampled midway between edges
  always @(negedge clk) begin
    #5;
    if (rst_n && wr_valid && wr_ready && n_log < 64) begin
      l_tag[n_log] = wr_tag; l_mask[n_log] = wr_mask; l_data[n_log] = wr_data;
      n_log++;
    end
  end

  task automatic send(logic [AW-1:0] a, logic [71:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_parity = w;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    model_accept(a, w);
    #1 in_valid = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush_req = 1'b1;
    @(negedge clk); flush_req = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic compare_log(string req);
    chk({req, " burst count"}, 576'(n_log), 576'(n_exp));
    for (int k = 0; k < n_exp && k < n_log; k++) begin
      chk({req, " tag"},  576'(l_tag[k]),  576'(e_tag[k]));
      chk({req, " mask"}, 576'(l_mask[k]), 576'(e_mask[k]));
      chk({req, " data"}, l_data[k], e_data[k]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle after reset
    chk("R1 wr_valid", 576'(wr_valid), 576'(0));
    chk("R1 in_ready", 576'(in_ready), 576'(1));
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 in_ready after release", 576'(in_ready), 576'(1));

    // R10: flush of an empty buffer
    pulse_flush();
    chk("R10 no burst on empty flush", 576'(n_log), 576'(0));

    // R2 R3 R4 R6 R7: vector walk (lane 3 of tag 2 rewritten -> R4)
    for (int i = 0; i < 10; i++) send(VEC[i][23:8], {9{VEC[i][7:0]}});
    pulse_flush();
    model_flush();
    compare_log("R2/R3/R4 walk");
    chk("R4 overwritten lane", l_data[0][3*72 +: 72], 576'({9{8'hD4}}));
    chk("R3 merged mask", 576'(l_mask[0]), 576'(8'h09));

    // R9: room left, nothing leaves
    send(16'h0200, {9{8'h11}});
    send(16'h0208, {9{8'h22}});
    send(16'h0210, {9{8'h33}});
    repeat (6) @(negedge clk);
    #1;
    chk("R9 no burst with room", 576'(n_log), 576'(n_exp));
    chk("R9 wr_valid low", 576'(wr_valid), 576'(0));
    pulse_flush();
    model_flush();
    compare_log("R7 flush order");

    // R6 R8: full buffer, new tag, memory side stalled
    send(16'h0100, {9{8'h5A}});
    send(16'h0109, {9{8'h6B}});
    send(16'h0112, {9{8'h7C}});
    send(16'h011B, {9{8'h8D}});
    @(negedge clk);
    wr_ready = 1'b0;
    in_valid = 1'b1; in_addr = 16'h0124; in_parity = {9{8'h9E}};
    #1;
    chk("R6 stall in_ready", 576'(in_ready), 576'(0));
    chk("R6 oldest presented", 576'(wr_tag), 576'(13'h020));
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      chk("R8 hold valid", 576'(wr_valid), 576'(1));
      chk("R8 hold mask", 576'(wr_mask), 576'(8'h01));
      chk("R8 hold data", wr_data, put_lane(0, {9{8'h5A}}));
    end
    wr_ready = 1'b1;
    #1;
    chk("R6 accept on release", 576'(in_ready), 576'(1));
    @(posedge clk);
    model_accept(16'h0124, {9{8'h9E}});
    #1 in_valid = 1'b0;
    pulse_flush();
    model_flush();
    compare_log("R6 evict");
    chk("R5 new slot mask", 576'(l_mask[n_log-1]), 576'(8'h10));
    chk("R5 other lanes zero", l_data[n_log-1], put_lane(4, {9{8'h9E}}));

    // R7: input blocked while a flush drains
    send(16'h0300, {9{8'h01}});
    send(16'h0311, {9{8'h02}});
    @(negedge clk);
    wr_ready = 1'b0; flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    in_valid = 1'b1; in_addr = 16'h0301; in_parity = {9{8'h03}};
    #1;
    chk("R7 in_ready low in flush", 576'(in_ready), 576'(0));
    chk("R7 draining", 576'(wr_valid), 576'(1));
    chk("R7 oldest first", 576'(wr_tag), 576'(13'h060));
    @(negedge clk);
    in_valid = 1'b0; wr_ready = 1'b1;
    repeat (12) @(negedge clk);
    model_flush();
    compare_log("R7 flush stalled");

    finish_run();
  end
endmodule